// File: doc/BRIEF.md
# Power-Management Event Status and Enable Registers

This block holds the event status and event enable registers of an ACPI-style power-management unit. It also holds a plain control register. Software reaches all three through a small register port. Several event sources latch into sticky status bits: a free-running power-management timer passing its next overflow point, a power-button press, a wake from sleep, a global-lock release and a real-time-clock alarm. Software acknowledges an event by writing 1 to its status bit.

The block drives a level-sensitive system control interrupt (`sci`). It is high while any enabled status bit that is SCI-capable is set. Timer overflow is detected lazily. A comparator checks the running count against a stored overflow point, and the status read path shows a reached point in the same cycle. The stored point moves to the next toggle of the counter's top bit only when software clears a set timer status bit.

Top module: `pm_evt_regs`

## Requirements
- R1: While `rst_n` is low, the status, enable and control registers read 0 and `sci` is 0. The timer count restarts at 0.
- R2: The byte offsets are 0x0 for status, 0x2 for enable and 0x4 for control. Any other offset ignores writes and reads as 0. The enable register keeps only bits 0, 5, 8, 10 and 13. The status register keeps only bits 0, 5, 8, 10 and 15. All other bits read 0.
- R3: A status write clears each bit that is 1 in the written data. Bits written as 0 keep their value.
- R4: A global-lock event sets status bit 5 and an RTC event sets status bit 10, whatever the enable bits hold. An event that sets a bit wins over a write that clears the same bit in the same cycle.
- R5: A power-button event sets status bit 8 only when enable bit 8 is 1.
- R6: A wake event sets both status bit 15 and status bit 8, whatever the enable bits hold.
- R7: `sci` is registered. At each clock edge it takes the OR over bits 0, 5, 8 and 10 of (next status AND next enable). Bits 13 and 15 never raise it.
- R8: Status bit 0 reads as 1 in the first cycle in which the timer count has reached or passed the stored overflow point, and it then stays set until cleared.
- R9: After reset the overflow point is 2^(TMR_W-1). When a status write clears a set bit 0, the point becomes the next count at which the counter's top bit toggles, measured from the current count. The counter keeps running through the clear.
- R10: The control register stores and returns all 16 bits written to it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | ADDR_W | Byte offset for both read and write |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| evt_pwrbtn | input | 1 | Power-button press, one pulse per event |
| evt_wake | input | 1 | Resume from sleep |
| evt_gbl | input | 1 | Global-lock release |
| evt_rtc | input | 1 | Real-time-clock alarm |
| tmr_count | output | TMR_W | Running power-management timer value |
| sci | output | 1 | System control interrupt, level |

## Verification
The bench targets four edge cases.

- **Clear and event in one cycle.** A design that lets the clear win loses the event, and its status reads 0 where 0x0020 is expected.
- **Power-button gating.** A design that ignores the enable bit latches the press while the enable is clear.
- **Lazy timer bit.** The bench reads status exactly at the overflow count and one count before it. A design that registers the bit first shows it one count late.
- **Re-arm after clearing.** The bench clears bit 0 past the midpoint and watches the count wrap. A design that keeps the old point, or rebuilds it from the wrong half, sets the bit again at once or at the wrong count.

The bench also writes 0xFFFF to the enable register, which checks the implemented-bit mask. It drives a wake while only the suspend enable is set, which checks that bit 15 and bit 13 never raise `sci`.

// File: rtl/pm_evt_pkg.sv
package pm_evt_pkg;
   localparam int REG_W      = 16;
   localparam int BIT_TMR    = 0;
   localparam int BIT_GBL    = 5;
   localparam int BIT_PWRBTN = 8;
   localparam int BIT_RTC    = 10;
   localparam int BIT_SUSP   = 13;
   localparam int BIT_WAKE   = 15;

   localparam logic [REG_W-1:0] SCI_MASK = REG_W'((1 << BIT_TMR) | (1 << BIT_GBL) |
                                                  (1 << BIT_PWRBTN) | (1 << BIT_RTC));
   localparam logic [REG_W-1:0] EN_MASK  = SCI_MASK | REG_W'(1 << BIT_SUSP);
   localparam logic [REG_W-1:0] STS_MASK = SCI_MASK | REG_W'(1 << BIT_WAKE);

   typedef enum logic [1:0] {
      SEL_STS  = 2'd0,
      SEL_EN   = 2'd1,
      SEL_CTL  = 2'd2,
      SEL_NONE = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/pm_free_timer.sv
module pm_free_timer #(
   parameter int TMR_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [TMR_W-1:0] count
);
   always_ff @(posedge clk) begin
      if (!rst_n) count <= '0;
      else        count <= count + TMR_W'(1);
   end
endmodule

// File: rtl/pm_ovf_cmp.sv
module pm_ovf_cmp #(
   parameter int TMR_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [TMR_W-1:0] count,
   input  logic             rearm,
   output logic             hit
);
   localparam logic [TMR_W-1:0] HALF = {1'b1, {(TMR_W-1){1'b0}}};

   logic [TMR_W-1:0] point_q;

   // next toggle of the top bit: the half boundary opposite to the current one
   always_ff @(posedge clk) begin
      if (!rst_n)     point_q <= HALF;
      else if (rearm) point_q <= {~count[TMR_W-1], {(TMR_W-1){1'b0}}};
   end

   // reached or passed: distance from the point lies in the first half-range
   assign hit = ((count - point_q) < HALF);
endmodule

// File: rtl/pm_evt_status.sv
module pm_evt_status
   import pm_evt_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  reg_sel_e         sel,
   input  logic             wr,
   input  logic [REG_W-1:0] wdata,
   input  logic             evt_pwrbtn,
   input  logic             evt_wake,
   input  logic             evt_gbl,
   input  logic             evt_rtc,
   input  logic             tmr_hit,
   output logic [REG_W-1:0] sts_q,
   output logic [REG_W-1:0] en_q,
   output logic [REG_W-1:0] ctl_q,
   output logic [REG_W-1:0] sts_view,
   output logic             tmr_rearm,
   output logic             sci
);
   logic [REG_W-1:0] clr, set_vec, sts_d, en_d;

   assign sts_view = sts_q | (REG_W'(tmr_hit) << BIT_TMR);
   assign clr      = (wr && sel == SEL_STS) ? (wdata & STS_MASK) : '0;

   always_comb begin
      set_vec             = '0;
      set_vec[BIT_GBL]    = evt_gbl;
      set_vec[BIT_RTC]    = evt_rtc;
      set_vec[BIT_PWRBTN] = (evt_pwrbtn && en_q[BIT_PWRBTN]) || evt_wake;
      set_vec[BIT_WAKE]   = evt_wake;
   end

   assign sts_d     = ((sts_view & ~clr) | set_vec) & STS_MASK;
   assign en_d      = (wr && sel == SEL_EN) ? (wdata & EN_MASK) : en_q;
   assign tmr_rearm = clr[BIT_TMR] && sts_view[BIT_TMR];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sts_q <= '0;
         en_q  <= '0;
         ctl_q <= '0;
         sci   <= 1'b0;
      end else begin
         sts_q <= sts_d;
         en_q  <= en_d;
         if (wr && sel == SEL_CTL) ctl_q <= wdata;
         sci   <= |(sts_d & en_d & SCI_MASK);
      end
   end
endmodule

// File: rtl/pm_evt_regs.sv
module pm_evt_regs
   import pm_evt_pkg::*;
#(
   parameter int TMR_W  = 24,
   parameter int ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [15:0]       reg_wdata,
   output logic [15:0]       reg_rdata,
   input  logic              evt_pwrbtn,
   input  logic              evt_wake,
   input  logic              evt_gbl,
   input  logic              evt_rtc,
   output logic [TMR_W-1:0]  tmr_count,
   output logic              sci
);
   localparam logic [ADDR_W-1:0] OFS_STS = ADDR_W'(0);
   localparam logic [ADDR_W-1:0] OFS_EN  = ADDR_W'(2);
   localparam logic [ADDR_W-1:0] OFS_CTL = ADDR_W'(4);

   generate
      if (TMR_W < 4) begin : g_bad_tmr
         $error("pm_evt_regs: TMR_W must be at least 4");
      end
      if (ADDR_W < 3) begin : g_bad_addr
         $error("pm_evt_regs: ADDR_W must reach offset 4");
      end
   endgenerate

   reg_sel_e         sel;
   logic             tmr_hit, tmr_rearm;
   logic [REG_W-1:0] sts_q, en_q, ctl_q, sts_view;

   always_comb begin
      if      (reg_addr == OFS_STS) sel = SEL_STS;
      else if (reg_addr == OFS_EN)  sel = SEL_EN;
      else if (reg_addr == OFS_CTL) sel = SEL_CTL;
      else                          sel = SEL_NONE;
   end

   pm_free_timer #(.TMR_W(TMR_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .count(tmr_count)
   );

   pm_ovf_cmp #(.TMR_W(TMR_W)) u_ovf (
      .clk(clk), .rst_n(rst_n), .count(tmr_count), .rearm(tmr_rearm), .hit(tmr_hit)
   );

   pm_evt_status u_status (
      .clk(clk), .rst_n(rst_n), .sel(sel), .wr(reg_wr), .wdata(reg_wdata),
      .evt_pwrbtn(evt_pwrbtn), .evt_wake(evt_wake), .evt_gbl(evt_gbl), .evt_rtc(evt_rtc),
      .tmr_hit(tmr_hit), .sts_q(sts_q), .en_q(en_q), .ctl_q(ctl_q),
      .sts_view(sts_view), .tmr_rearm(tmr_rearm), .sci(sci)
   );

   always_comb begin
      unique case (sel)
         SEL_STS: reg_rdata = sts_view;
         SEL_EN:  reg_rdata = en_q;
         SEL_CTL: reg_rdata = ctl_q;
         default: reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/pm_evt_regs_chk.sv
module pm_evt_regs_chk #(
   parameter int ADDR_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [15:0]       reg_wdata,
   input logic              evt_pwrbtn,
   input logic              evt_wake,
   input logic              evt_rtc,
   input logic              sci,
   input logic [15:0]       sts_q,
   input logic [15:0]       en_q,
   input logic              tmr_hit
);
   logic sts_wr;
   assign sts_wr = reg_wr && (reg_addr == ADDR_W'(0));

   assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (sts_q == 16'h0 && en_q == 16'h0 && !sci));

   assert_sci_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
      sci == |(sts_q & en_q & 16'h0521));

   assert_w1c_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_wr && reg_wdata[10] && !evt_rtc) |=> !sts_q[10]);

   assert_pwrbtn_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_pwrbtn && !en_q[8] && !evt_wake && !sts_q[8]) |=> !sts_q[8]);

   assert_wake_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
      evt_wake |=> (sts_q[15] && sts_q[8]));

   assert_ovf_latch_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr_hit && !(sts_wr && reg_wdata[0])) |=> sts_q[0]);
endmodule

bind pm_evt_regs pm_evt_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
   .reg_wdata(reg_wdata), .evt_pwrbtn(evt_pwrbtn), .evt_wake(evt_wake),
   .evt_rtc(evt_rtc), .sci(sci), .sts_q(sts_q), .en_q(en_q), .tmr_hit(tmr_hit)
);

// File: tb/pm_evt_regs_test.sv
`timescale 1ns/1ps
module pm_evt_regs_test;
   localparam int TW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr = 1'b0;
   logic [2:0]    reg_addr = '0;
   logic [15:0]   reg_wdata = '0;
   logic [15:0]   reg_rdata;
   logic          evt_pwrbtn = 1'b0, evt_wake = 1'b0, evt_gbl = 1'b0, evt_rtc = 1'b0;
   logic [TW-1:0] tmr_count;
   logic          sci;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #10 clk = ~clk;

   pm_evt_regs #(.TMR_W(TW), .ADDR_W(3)) uut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_pwrbtn(evt_pwrbtn),
      .evt_wake(evt_wake), .evt_gbl(evt_gbl), .evt_rtc(evt_rtc),
      .tmr_count(tmr_count), .sci(sci)
   );

   // evt order: {wake, pwrbtn, gbl, rtc}
   typedef struct packed {
      logic [3:0]  req;
      logic        wr;
      logic [2:0]  addr;
      logic [15:0] wdata;
      logic [3:0]  evt;
      logic [2:0]  raddr;
      logic [15:0] exp_rd;
      logic        exp_sci;
   } vec_t;

   localparam int NV = 19;
   localparam vec_t VEC [NV] = '{
      '{4'd2,  1'b1, 3'd2, 16'h0100, 4'b0000, 3'd2, 16'h0100, 1'b0}, // R2 enable write
      '{4'd5,  1'b0, 3'd0, 16'h0000, 4'b0100, 3'd0, 16'h0100, 1'b1}, // R5 enabled press
      '{4'd3,  1'b1, 3'd0, 16'h0000, 4'b0000, 3'd0, 16'h0100, 1'b1}, // R3 zeros keep
      '{4'd3,  1'b1, 3'd0, 16'h0100, 4'b0000, 3'd0, 16'h0000, 1'b0}, // R3 one clears
      '{4'd2,  1'b1, 3'd2, 16'h0000, 4'b0000, 3'd2, 16'h0000, 1'b0}, // R2
      '{4'd5,  1'b0, 3'd0, 16'h0000, 4'b0100, 3'd0, 16'h0000, 1'b0}, // R5 press ignored
      '{4'd4,  1'b0, 3'd0, 16'h0000, 4'b0010, 3'd0, 16'h0020, 1'b0}, // R4 gbl unconditional
      '{4'd7,  1'b1, 3'd2, 16'h0020, 4'b0000, 3'd2, 16'h0020, 1'b1}, // R7 enable raises sci
      '{4'd4,  1'b0, 3'd0, 16'h0000, 4'b0001, 3'd0, 16'h0420, 1'b1}, // R4 rtc
      '{4'd7,  1'b1, 3'd0, 16'h0020, 4'b0000, 3'd0, 16'h0400, 1'b0}, // R7 drop
      '{4'd2,  1'b1, 3'd2, 16'hFFFF, 4'b0000, 3'd2, 16'h2521, 1'b1}, // R2 enable mask
      '{4'd6,  1'b0, 3'd0, 16'h0000, 4'b1000, 3'd0, 16'h8500, 1'b1}, // R6 wake
      '{4'd4,  1'b1, 3'd0, 16'hFFFF, 4'b0010, 3'd0, 16'h0020, 1'b1}, // R4 set beats clear
      '{4'd3,  1'b1, 3'd0, 16'h0020, 4'b0000, 3'd0, 16'h0000, 1'b0}, // R3
      '{4'd7,  1'b1, 3'd2, 16'h2000, 4'b1000, 3'd0, 16'h8100, 1'b0}, // R7 bits 13/15 no sci, R6
      '{4'd10, 1'b1, 3'd4, 16'hA5C3, 4'b0000, 3'd4, 16'hA5C3, 1'b0}, // R10 control
      '{4'd3,  1'b1, 3'd0, 16'h8100, 4'b0000, 3'd0, 16'h0000, 1'b0}, // R3
      '{4'd2,  1'b1, 3'd6, 16'hFFFF, 4'b0000, 3'd6, 16'h0000, 1'b0}, // R2 unmapped
      '{4'd2,  1'b0, 3'd0, 16'h0000, 4'b0000, 3'd2, 16'h2000, 1'b0}  // R2 enable untouched
   };

   task automatic check(input bit ok, input int req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL R%0d actual=0x%04h expected=0x%04h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(posedge clk); #1;
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [15:0] d);
      reg_addr = a; #1;
      d = reg_rdata;
   endtask

   task automatic wait_cnt(input logic [TW-1:0] v);
      do @(negedge clk); while (tmr_count !== v);
   endtask

   initial begin
      logic [15:0] r;
      repeat (3) @(negedge clk);
      // R1 reset state
      rd(3'd0, r); check(r == 16'h0, 1, r, 16'h0);
      rd(3'd2, r); check(r == 16'h0, 1, r, 16'h0);
      check(sci == 1'b0, 1, 16'(sci), 16'h0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         reg_wr = VEC[i].wr; reg_addr = VEC[i].addr; reg_wdata = VEC[i].wdata;
         {evt_wake, evt_pwrbtn, evt_gbl, evt_rtc} = VEC[i].evt;
         @(posedge clk); #1;
         reg_wr = 1'b0; {evt_wake, evt_pwrbtn, evt_gbl, evt_rtc} = 4'b0;
         rd(VEC[i].raddr, r);
         check(r == VEC[i].exp_rd, int'(VEC[i].req), r, VEC[i].exp_rd);
         check(sci == VEC[i].exp_sci, int'(VEC[i].req), 16'(sci), 16'(VEC[i].exp_sci));
      end

      // R8 lazy timer status around the first overflow point (128)
      wait_cnt(8'd99);
      wr(3'd2, 16'h0001);
      wait_cnt(8'd127);
      rd(3'd0, r); check(r == 16'h0000, 8, r, 16'h0000);
      wait_cnt(8'd128);
      rd(3'd0, r); check(r == 16'h0001, 8, r, 16'h0001);
      wait_cnt(8'd129);
      check(sci == 1'b1, 7, 16'(sci), 16'h1);
      // R9 clear at count 140 moves the point to the wrap
      wait_cnt(8'd139);
      wr(3'd0, 16'h0001);
      rd(3'd0, r); check(r == 16'h0000, 9, r, 16'h0000);
      check(sci == 1'b0, 9, 16'(sci), 16'h0);
      check(tmr_count == 8'd141, 9, 16'(tmr_count), 16'd141);
      wait_cnt(8'd255);
      rd(3'd0, r); check(r == 16'h0000, 9, r, 16'h0000);
      wait_cnt(8'd0);
      rd(3'd0, r); check(r == 16'h0001, 9, r, 16'h0001);
      wait_cnt(8'd1);
      check(sci == 1'b1, 9, 16'(sci), 16'h1);

      // R1 reset mid-run
      @(negedge clk); rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rd(3'd0, r); check(r == 16'h0, 1, r, 16'h0);
      rd(3'd2, r); check(r == 16'h0, 1, r, 16'h0);
      rd(3'd4, r); check(r == 16'h0, 1, r, 16'h0);
      check(sci == 1'b0, 1, 16'(sci), 16'h0);
      check(tmr_count == '0, 1, 16'(tmr_count), 16'h0);

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule